// File: doc/BRIEF.md
# Clocked Register-Bus Slave Node

This block is the slave end of a three-wire serial register bus. The master drives a bus clock and a data line toward the slave, and the slave answers on its own data-out line. Inside the node sits a small bank of 8-bit registers, and the application side of the chip reads and writes that bank through a plain indexed port.

Each transfer opens with a 16-bit header. The header names a node, says whether the master wants to read or write, and picks a starting register. After the header the master keeps clocking. Bytes then stream to or from consecutive registers, and the register index advances by one after every byte. When the bus clock has been quiet for a set number of system clocks, the transfer is over and the node waits for a fresh header. Both bus lines are brought into the system clock domain through a synchronizer, and the node detects bus clock edges by oversampling. Writes sent to the all-ones broadcast address are taken by every node.

Top module: `regbus_slave`

## Requirements
- R1: The header is sent MSB first and is 16 bits long: node address in bits 15..8, read flag in bit 7 (1 = read, 0 = write), starting register index in bits 6..0. The slave samples data-in on rising bus-clock edges.
- R2: On a read addressed to this node, the slave sends the starting register and then each following register, MSB first. Each new bit is presented after a falling bus-clock edge, so the master samples it on the next rising edge. The first data bit follows the falling edge that comes after the 16th header bit.
- R3: On a write accepted by this node, every group of 8 received bits is stored into the current register, and the index then moves to the next register.
- R4: Registers at or above NUM_REGS (default 16) read as 8'hFF on both the bus and the application port. Writes to them have no effect.
- R5: When the bus clock shows no edge for IDLE_CYCLES system clocks, the transfer ends. Data-out is released and a partially received header is discarded.
- R6: Writes to address 8'hFF are accepted by every node. A read to 8'hFF is not answered.
- R7: A transfer whose address is neither this node's address nor 8'hFF changes no register and drives nothing.
- R8: The data-out enable is high only during the read phase of a transfer addressed to this node. While it is low, data-out is held at 1.
- R9: During a burst the register index wraps from 127 to 0.
- R10: After reset all registers hold 0 and data-out is released.
- R11: The application port reads any register combinationally and writes it on a clock edge. If the bus writes the same register in the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_addr_i | input | 8 | This node's bus address |
| bus_clk_i | input | 1 | Bus clock from the master (idle low) |
| bus_din_i | input | 1 | Serial data from master to slave |
| bus_dout_o | output | 1 | Serial data from slave to master, 1 when released |
| bus_dout_en_o | output | 1 | High while the node drives data-out |
| app_we_i | input | 1 | Application write strobe |
| app_idx_i | input | 7 | Application register index |
| app_wdata_i | input | 8 | Application write data |
| app_rdata_o | output | 8 | Application read data for app_idx_i |

## Verification
The bench targets these corner cases:
- Bursts that cross index 127. A design without the wrap would stall there or run past the bank.
- Bursts that move through unimplemented registers. A design without the all-ones fill would return stale or zero bytes.
- Broadcast reads. A design that answered them would drive data-out on a shared wire.
- A header that is cut off and then resumed after the idle timeout. A design that does not clear its shift state would misread the next header.
- A header whose address is this node's address bit-reversed. A design that shifted LSB first would accept it.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   typedef enum logic [1:0] {
      PH_HDR   = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2,
      PH_SKIP  = 2'd3
   } phase_t;

endpackage

// File: rtl/rbs_edge_sync.sv
module rbs_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_clk_i,
   input  logic bus_din_i,
   output logic rise_o,
   output logic fall_o,
   output logic din_o
);

   logic [SYNC_STAGES-1:0] clk_pipe;
   logic [SYNC_STAGES-1:0] din_pipe;
   logic                   clk_prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("rbs_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  clk_pipe[0] <= 1'b0;
                  din_pipe[0] <= 1'b0;
               end else begin
                  clk_pipe[0] <= bus_clk_i;
                  din_pipe[0] <= bus_din_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  clk_pipe[s] <= 1'b0;
                  din_pipe[s] <= 1'b0;
               end else begin
                  clk_pipe[s] <= clk_pipe[s-1];
                  din_pipe[s] <= din_pipe[s-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= clk_pipe[SYNC_STAGES-1];
   end

   assign rise_o = clk_pipe[SYNC_STAGES-1] & ~clk_prev;
   assign fall_o = ~clk_pipe[SYNC_STAGES-1] & clk_prev;
   assign din_o  = din_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/rbs_idle_timer.sv
module rbs_idle_timer #(
   parameter int IDLE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic activity_i,
   output logic timeout_o
);

   localparam int TW = $clog2(IDLE_CYCLES + 1);
   localparam logic [TW-1:0] LIMIT     = TW'(IDLE_CYCLES);
   localparam logic [TW-1:0] LAST_TICK = TW'(IDLE_CYCLES - 1);

   logic [TW-1:0] quiet_cnt;

   generate
      if (IDLE_CYCLES < 4) begin : g_bad_idle
         $error("rbs_idle_timer: IDLE_CYCLES must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  quiet_cnt <= '0;
      else if (activity_i)         quiet_cnt <= '0;
      else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + TW'(1);
   end

   // Fires once per quiet spell: afterwards the count parks at LIMIT.
   assign timeout_o = (quiet_cnt == LAST_TICK) && !activity_i;

endmodule

// File: rtl/rbs_reg_bank.sv
module rbs_reg_bank #(
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 7,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we_i,
   input  logic [IDX_W-1:0]  bus_widx_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic [IDX_W-1:0]  bus_ridx_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              app_we_i,
   input  logic [IDX_W-1:0]  app_idx_i,
   input  logic [DATA_W-1:0] app_wdata_i,
   output logic [DATA_W-1:0] app_rdata_o
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (bus_we_i && bus_widx_i == IDX_W'(g))
               regs[g] <= bus_wdata_i;
            else if (app_we_i && app_idx_i == IDX_W'(g))
               regs[g] <= app_wdata_i;
         end
      end
   endgenerate

   // Unimplemented indices fall through to all ones.
   always_comb begin
      bus_rdata_o = '1;
      app_rdata_o = '1;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (bus_ridx_i == IDX_W'(i)) bus_rdata_o = regs[i];
         if (app_idx_i == IDX_W'(i))  app_rdata_o = regs[i];
      end
   end

endmodule

// File: rtl/rbs_frame_ctl.sv
module rbs_frame_ctl
   import regbus_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              din_i,
   input  logic              timeout_i,
   input  logic [ADDR_W-1:0] node_addr_i,
   input  logic [DATA_W-1:0] bank_rdata_i,
   output logic [IDX_W-1:0]  bank_ridx_o,
   output logic              bank_we_o,
   output logic [IDX_W-1:0]  bank_widx_o,
   output logic [DATA_W-1:0] bank_wdata_o,
   output logic              dout_o,
   output logic              dout_en_o
);

   localparam int HDR_W  = ADDR_W + 1 + IDX_W;
   localparam int HCNT_W = $clog2(HDR_W);
   localparam int BCNT_W = $clog2(DATA_W);
   localparam logic [HCNT_W-1:0] HDR_LAST  = HCNT_W'(HDR_W - 1);
   localparam logic [BCNT_W-1:0] BYTE_LAST = BCNT_W'(DATA_W - 1);
   localparam logic [ADDR_W-1:0] BCAST     = '1;

   phase_t             phase;
   logic [HDR_W-2:0]   hdr_sr;
   logic [HCNT_W-1:0]  hdr_cnt;
   logic [BCNT_W-1:0]  bcnt;
   logic [IDX_W-1:0]   cur_idx;
   logic [DATA_W-1:0]  tx_sr;
   logic [DATA_W-2:0]  rx_sr;
   logic               dout_q;

   logic [HDR_W-1:0]   hdr_full;
   logic [ADDR_W-1:0]  hdr_addr;
   logic               hdr_rd;
   logic [IDX_W-1:0]   hdr_idx;
   logic               hdr_last;
   logic [IDX_W-1:0]   next_idx;

   assign hdr_full = {hdr_sr, din_i};
   assign hdr_addr = hdr_full[HDR_W-1 -: ADDR_W];
   assign hdr_rd   = hdr_full[IDX_W];
   assign hdr_idx  = hdr_full[IDX_W-1:0];
   assign hdr_last = (hdr_cnt == HDR_LAST);
   assign next_idx = cur_idx + IDX_W'(1);

   assign bank_ridx_o  = (phase == PH_HDR) ? hdr_idx : next_idx;
   assign bank_we_o    = (phase == PH_WRITE) && rise_i && (bcnt == BYTE_LAST);
   assign bank_widx_o  = cur_idx;
   assign bank_wdata_o = {rx_sr, din_i};

   assign dout_en_o = (phase == PH_READ);
   assign dout_o    = dout_en_o ? dout_q : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_HDR;
         hdr_sr  <= '0;
         hdr_cnt <= '0;
         bcnt    <= '0;
         cur_idx <= '0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         dout_q  <= 1'b1;
      end else if (timeout_i) begin
         phase   <= PH_HDR;
         hdr_sr  <= '0;
         hdr_cnt <= '0;
         bcnt    <= '0;
         dout_q  <= 1'b1;
      end else begin
         unique case (phase)
            PH_HDR: begin
               if (rise_i) begin
                  hdr_sr <= hdr_full[HDR_W-2:0];
                  if (hdr_last) begin
                     hdr_cnt <= '0;
                     bcnt    <= '0;
                     cur_idx <= hdr_idx;
                     dout_q  <= 1'b1;
                     if (hdr_rd) begin
                        if (hdr_addr == node_addr_i) begin
                           phase <= PH_READ;
                           tx_sr <= bank_rdata_i;
                        end else begin
                           phase <= PH_SKIP;
                        end
                     end else if (hdr_addr == node_addr_i || hdr_addr == BCAST) begin
                        phase <= PH_WRITE;
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end else begin
                     hdr_cnt <= hdr_cnt + HCNT_W'(1);
                  end
               end
            end
            PH_READ: begin
               if (fall_i) begin
                  dout_q <= tx_sr[DATA_W-1];
                  if (bcnt == BYTE_LAST) begin
                     bcnt    <= '0;
                     tx_sr   <= bank_rdata_i;
                     cur_idx <= next_idx;
                  end else begin
                     bcnt  <= bcnt + BCNT_W'(1);
                     tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                  end
               end
            end
            PH_WRITE: begin
               if (rise_i) begin
                  rx_sr <= {rx_sr[DATA_W-3:0], din_i};
                  if (bcnt == BYTE_LAST) begin
                     bcnt    <= '0;
                     cur_idx <= next_idx;
                  end else begin
                     bcnt <= bcnt + BCNT_W'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
   parameter int ADDR_W      = 8,
   parameter int IDX_W       = 7,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 16,
   parameter int IDLE_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] node_addr_i,
   input  logic              bus_clk_i,
   input  logic              bus_din_i,
   output logic              bus_dout_o,
   output logic              bus_dout_en_o,
   input  logic              app_we_i,
   input  logic [IDX_W-1:0]  app_idx_i,
   input  logic [DATA_W-1:0] app_wdata_i,
   output logic [DATA_W-1:0] app_rdata_o
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
         $error("regbus_slave: NUM_REGS must lie in 1..2**IDX_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("regbus_slave: DATA_W must be at least 3");
      end
      if (ADDR_W < 1 || IDX_W < 1) begin : g_bad_hdr
         $error("regbus_slave: header fields must be non-empty");
      end
   endgenerate

   logic              edge_rise;
   logic              edge_fall;
   logic              din_sync;
   logic              idle_to;
   logic              bus_we;
   logic [IDX_W-1:0]  bus_widx;
   logic [DATA_W-1:0] bus_wdata;
   logic [IDX_W-1:0]  bus_ridx;
   logic [DATA_W-1:0] bus_rdata;

   rbs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_clk_i (bus_clk_i),
      .bus_din_i (bus_din_i),
      .rise_o    (edge_rise),
      .fall_o    (edge_fall),
      .din_o     (din_sync)
   );

   rbs_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .activity_i (edge_rise | edge_fall),
      .timeout_o  (idle_to)
   );

   rbs_frame_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_i       (edge_rise),
      .fall_i       (edge_fall),
      .din_i        (din_sync),
      .timeout_i    (idle_to),
      .node_addr_i  (node_addr_i),
      .bank_rdata_i (bus_rdata),
      .bank_ridx_o  (bus_ridx),
      .bank_we_o    (bus_we),
      .bank_widx_o  (bus_widx),
      .bank_wdata_o (bus_wdata),
      .dout_o       (bus_dout_o),
      .dout_en_o    (bus_dout_en_o)
   );

   rbs_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we_i    (bus_we),
      .bus_widx_i  (bus_widx),
      .bus_wdata_i (bus_wdata),
      .bus_ridx_i  (bus_ridx),
      .bus_rdata_o (bus_rdata),
      .app_we_i    (app_we_i),
      .app_idx_i   (app_idx_i),
      .app_wdata_i (app_wdata_i),
      .app_rdata_o (app_rdata_o)
   );

endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
   parameter int IDX_W    = 7,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              fall,
   input logic              timeout,
   input logic              bank_we,
   input logic              dout,
   input logic              dout_en,
   input logic [IDX_W-1:0]  app_idx,
   input logic [DATA_W-1:0] app_rdata
);

   // R8
   released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> dout);

   // R8
   en_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_en) |-> $past(rise));

   // R5
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !dout_en);

   // R4
   unimpl_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(app_idx) >= NUM_REGS) |-> (app_rdata == '1));

   // R2
   dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en && !fall && !timeout) |=> (!dout_en || $stable(dout)));

   // R3
   we_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> rise);

endmodule

bind regbus_slave regbus_slave_chk #(
   .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rise      (edge_rise),
   .fall      (edge_fall),
   .timeout   (idle_to),
   .bank_we   (bus_we),
   .dout      (bus_dout_o),
   .dout_en   (bus_dout_en_o),
   .app_idx   (app_idx_i),
   .app_rdata (app_rdata_o)
);

// File: tb/sim_regbus_slave.sv
module sim_regbus_slave;

   localparam int IDLE = 40;
   localparam int HALF = 8;
   localparam logic [7:0] ME = 8'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_clk = 1'b0;
   logic       bus_din = 1'b0;
   logic       bus_dout;
   logic       bus_dout_en;
   logic       app_we = 1'b0;
   logic [6:0] app_idx = '0;
   logic [7:0] app_wdata = '0;
   logic [7:0] app_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   regbus_slave #(.NUM_REGS(16), .IDLE_CYCLES(IDLE)) u0 (
      .clk(clk), .rst_n(rst_n), .node_addr_i(ME),
      .bus_clk_i(bus_clk), .bus_din_i(bus_din),
      .bus_dout_o(bus_dout), .bus_dout_en_o(bus_dout_en),
      .app_we_i(app_we), .app_idx_i(app_idx),
      .app_wdata_i(app_wdata), .app_rdata_o(app_rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_bit(input logic b, output logic smp, output logic en_smp);
      bus_din = b;
      repeat (HALF) @(negedge clk);
      smp = bus_dout;
      en_smp = bus_dout_en;
      bus_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      bus_clk = 1'b0;
   endtask

   task automatic send_hdr(input logic [7:0] addr, input logic rd, input logic [6:0] idx);
      logic [15:0] h;
      logic s, e;
      h = {addr, rd, idx};
      for (int i = 15; i >= 0; i--) bus_bit(h[i], s, e);
   endtask

   task automatic write_byte(input logic [7:0] d);
      logic s, e;
      for (int i = 7; i >= 0; i--) bus_bit(d[i], s, e);
   endtask

   // en_all is 1 only if the enable was high at every sample point.
   task automatic read_byte(output logic [7:0] d, output logic en_all);
      logic s, e;
      en_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b0, s, e);
         d[i] = s;
         en_all &= e;
      end
   endtask

   task automatic go_idle();
      bus_clk = 1'b0;
      repeat (IDLE + 10) @(negedge clk);
   endtask

   task automatic app_read(input logic [6:0] idx, output logic [7:0] d);
      app_idx = idx;
      @(negedge clk);
      d = app_rdata;
   endtask

   // {addr, idx, wdata, expected readback at idx from own address}
   localparam int NV = 6;
   localparam logic [30:0] VEC [NV] = '{
      {8'h2A, 7'd3,  8'h5A, 8'h5A},   // R1 R3 own write
      {8'hFF, 7'd4,  8'hC3, 8'hC3},   // R6 broadcast write accepted
      {8'h11, 7'd5,  8'h77, 8'h00},   // R7 other node ignored
      {8'h2A, 7'd20, 8'h99, 8'hFF},   // R4 unimplemented reads ones
      {8'h54, 7'd9,  8'h33, 8'h00},   // R1 bit-reversed address ignored
      {8'h2A, 7'd15, 8'h80, 8'h80}    // R3 last implemented register
   };

   initial begin
      logic [7:0] r;
      logic en;
      repeat (5) @(negedge clk);
      // R10 reset state
      check("R10 dout_en after reset", {7'd0, bus_dout_en}, 8'h00);
      check("R10 dout after reset", {7'd0, bus_dout}, 8'h01);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      app_read(7'd0, r);
      check("R10 reg0 after reset", r, 8'h00);

      for (int v = 0; v < NV; v++) begin
         send_hdr(VEC[v][30:23], 1'b0, VEC[v][22:16]);
         write_byte(VEC[v][15:8]);
         go_idle();
         send_hdr(ME, 1'b1, VEC[v][22:16]);
         read_byte(r, en);
         go_idle();
         check($sformatf("R1/R3/R4/R6/R7 vector %0d", v), r, VEC[v][7:0]);
      end

      // R9 R3 burst write wrapping from 126
      send_hdr(ME, 1'b0, 7'd126);
      write_byte(8'hA1); write_byte(8'hA2); write_byte(8'hB3); write_byte(8'hC4);
      go_idle();
      app_read(7'd0, r); check("R9 wrapped write reg0", r, 8'hB3);
      app_read(7'd1, r); check("R9 wrapped write reg1", r, 8'hC4);

      // R2 R4 R9 R8 burst read wrapping
      send_hdr(ME, 1'b1, 7'd126);
      read_byte(r, en); check("R4 burst read idx126", r, 8'hFF);
      check("R8 enable during read", {7'd0, en}, 8'h01);
      read_byte(r, en); check("R4 burst read idx127", r, 8'hFF);
      read_byte(r, en); check("R9 R2 burst read idx0", r, 8'hB3);
      read_byte(r, en); check("R9 R2 burst read idx1", r, 8'hC4);
      go_idle();
      check("R5 released after idle", {7'd0, bus_dout_en}, 8'h00);

      // R2 R3 multi-byte burst inside the bank
      send_hdr(ME, 1'b0, 7'd10);
      write_byte(8'h10); write_byte(8'h20); write_byte(8'h30);
      go_idle();
      send_hdr(ME, 1'b1, 7'd10);
      read_byte(r, en); check("R2 burst idx10", r, 8'h10);
      read_byte(r, en); check("R2 burst idx11", r, 8'h20);
      read_byte(r, en); check("R2 burst idx12", r, 8'h30);
      go_idle();

      // R6 R8 broadcast read not answered
      send_hdr(8'hFF, 1'b1, 7'd3);
      read_byte(r, en);
      check("R6 broadcast read dout", r, 8'hFF);
      check("R6 broadcast read enable", {7'd0, en}, 8'h00);
      go_idle();

      // R7 read to another node not driven
      send_hdr(8'h11, 1'b1, 7'd3);
      read_byte(r, en);
      check("R7 other node read enable", {7'd0, en}, 8'h00);
      go_idle();

      // R5 partial header discarded after timeout
      for (int i = 0; i < 5; i++) begin
         logic s, e;
         bus_bit(1'b1, s, e);
      end
      go_idle();
      send_hdr(ME, 1'b0, 7'd2);
      write_byte(8'h5C);
      go_idle();
      app_read(7'd2, r); check("R5 header after timeout", r, 8'h5C);

      // R11 application write seen by bus read
      app_idx = 7'd7; app_wdata = 8'hE7; app_we = 1'b1;
      @(negedge clk);
      app_we = 1'b0;
      send_hdr(ME, 1'b1, 7'd7);
      read_byte(r, en); check("R11 app write via bus read", r, 8'hE7);
      go_idle();

      // R4 application read of unimplemented index; write has no effect
      app_idx = 7'd100; app_wdata = 8'h00; app_we = 1'b1;
      @(negedge clk);
      app_we = 1'b0;
      app_read(7'd100, r); check("R4 app unimplemented", r, 8'hFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule